// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is a small control sequencer for a multi-cycle processor. The main instruction state machine calls it at the end of every instruction and waits for it to finish before the next fetch starts. Three kinds of event can redirect execution: an instruction fault, a program-requested trap, and an external device request. A device request carries a priority and is taken only when it is enabled and outranks the level the processor is running at. Whichever event wins goes through the same entry path. The sequencer pushes the status word and then the program counter onto a supervisor stack that grows downward. It reads the handler address from a fixed vector table and hands the new PC, status word and stack pointer back to the register file.

The same block carries out the return-from-handler operation. It pops the saved PC and status word from the stack and hands them back together with the restored stack pointer. Because the saved state lives on the stack, nested entries unwind in the reverse order of entry. Memory is a single synchronous port: read data appears the cycle after the request.

The status word layout used throughout is as follows. Bit 15 is the privilege bit (1 = user, 0 = supervisor). Bits 10:8 hold the running priority. The remaining bits are condition flags and other state that pass through unchanged.

Top module: `excp_entry_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `done`, `irq_ack`, `sync_ack`, `pc_load`, `psr_load`, `sp_load`, `mem_req` and `mem_we` are all 0.
- R2: When `boundary` is sampled high and no event is taken, `done` pulses in the cycle right after that edge. No memory access and no register load take place.
- R3: A device request is taken only if `irq_en` is 1 and `irq_prio` is strictly greater than `psr_in[10:8]`. An equal or lower priority, or a cleared enable, leaves the request ignored.
- R4: Precedence among simultaneous requests is fault (`exc_req`) first, then trap (`trap_req`), then device. The winner's vector is the one used.
- R5: On entry, the block writes `psr_in` to address `sp_in-1` and then `pc_in` to address `sp_in-2`. These are two consecutive memory writes.
- R6: After the pushes, the block reads address `VEC_BASE + vector`, where `VEC_BASE` defaults to 0x0100 and the vector is 8 bits. The word read becomes `pc_out`, and `sp_out` is `sp_in-2`.
- R7: The entry status word is `psr_in` with bit 15 cleared. For a device event, bits 10:8 are also replaced by `irq_prio`. For a fault or trap, those bits are kept.
- R8: On return (`rti_req`), the block reads address `sp_in` and then address `sp_in+1`. It outputs `pc_out` = word at `sp_in`, `psr_out` = word at `sp_in+1`, and `sp_out` = `sp_in+2`.
- R9: `irq_ack` (device taken) or `sync_ack` (fault or trap taken) pulses for one cycle, right after the edge that samples `boundary`. The two are never high together.
- R10: `done` pulses for one cycle together with `pc_load`, `psr_load` and `sp_load`. This happens 5 cycles after the sampling edge for an entry and 4 cycles after it for a return.
- R11: Requests and the `boundary` and `rti_req` strobes are ignored while a sequence is in progress. Saved entries unwind in reverse order of entry (last in, first out).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Instruction finished; check for events |
| rti_req | input | 1 | Execute return-from-handler |
| done | output | 1 | Sequence finished; main FSM may fetch |
| exc_req | input | 1 | Synchronous fault request |
| exc_vec | input | 8 | Fault vector number |
| trap_req | input | 1 | Program trap request |
| trap_vec | input | 8 | Trap vector number |
| irq_req | input | 1 | Device request |
| irq_vec | input | 8 | Device vector number |
| irq_prio | input | 3 | Device priority |
| irq_en | input | 1 | Device requests enabled |
| irq_ack | output | 1 | Device request taken |
| sync_ack | output | 1 | Fault or trap taken |
| pc_in | input | 16 | Current PC |
| psr_in | input | 16 | Current status word |
| sp_in | input | 16 | Current supervisor stack pointer |
| pc_out | output | 16 | New PC |
| psr_out | output | 16 | New status word |
| sp_out | output | 16 | New stack pointer |
| pc_load | output | 1 | Load `pc_out` |
| psr_load | output | 1 | Load `psr_out` |
| sp_load | output | 1 | Load `sp_out` |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after a read request |

## Verification
The directed patterns set a device request against the running priority at one level below, equal and above, with the enable both off and on. This separates a strict from a non-strict comparison and shows whether the enable gates acceptance. Fault, trap and device requests are raised together and then in pairs, which shows whether the precedence order is right. A nested case enters at one priority, refuses an equal one, accepts a higher one and then returns twice. It shows whether the stack unwinds last in, first out and restores each status word exactly. The random mix pairs every taken entry with a return and compares the restored PC, status word and stack pointer with the originals.

// File: rtl/excp_seq_pkg.sv
package excp_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PUSH_SR,
    S_PUSH_PC,
    S_VEC_RD,
    S_VEC_WT,
    S_VEC_LD,
    S_RET_A,
    S_RET_B,
    S_RET_C,
    S_RET_D
  } seq_state_t;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_FAULT,
    SRC_TRAP,
    SRC_DEV
  } evt_src_t;

endpackage

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import excp_seq_pkg::*;
#(
  parameter int VW = 8,
  parameter int PW = 3
) (
  input  logic          fault_req,
  input  logic [VW-1:0] fault_vec,
  input  logic          trap_req,
  input  logic [VW-1:0] trap_vec,
  input  logic          dev_req,
  input  logic [VW-1:0] dev_vec,
  input  logic [PW-1:0] dev_prio,
  input  logic          dev_en,
  input  logic [PW-1:0] cur_prio,
  output logic          take,
  output evt_src_t      sel_src,
  output logic [VW-1:0] sel_vec
);

  logic dev_ok;

  // A device request must be enabled and strictly outrank the running level.
  assign dev_ok = dev_req && dev_en && (dev_prio > cur_prio);

  // Synchronous sources win over the device, and a fault wins over a trap.
  always_comb begin
    sel_src = SRC_NONE;
    sel_vec = '0;
    if (fault_req) begin
      sel_src = SRC_FAULT;
      sel_vec = fault_vec;
    end else if (trap_req) begin
      sel_src = SRC_TRAP;
      sel_vec = trap_vec;
    end else if (dev_ok) begin
      sel_src = SRC_DEV;
      sel_vec = dev_vec;
    end
  end

  assign take = (sel_src != SRC_NONE);

endmodule

// File: rtl/psr_builder.sv
module psr_builder #(
  parameter int DW       = 16,
  parameter int PRIV_POS = 15,
  parameter int PRIO_LSB = 8,
  parameter int PW       = 3
) (
  input  logic [DW-1:0] psr_old,
  input  logic          raise,
  input  logic [PW-1:0] prio,
  output logic [DW-1:0] psr_new
);

  localparam int PRIO_MSB = PRIO_LSB + PW - 1;

  // Per-bit selection: privilege forced to supervisor, priority field
  // optionally replaced, every other bit passed through.
  for (genvar g = 0; g < DW; g++) begin : g_bit
    if (g == PRIV_POS) begin : g_priv
      assign psr_new[g] = 1'b0;
    end else if (g >= PRIO_LSB && g <= PRIO_MSB) begin : g_prio
      assign psr_new[g] = raise ? prio[g-PRIO_LSB] : psr_old[g];
    end else begin : g_keep
      assign psr_new[g] = psr_old[g];
    end
  end

endmodule

// File: rtl/seq_core.sv
module seq_core
  import excp_seq_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 16,
  parameter int          VW       = 8,
  parameter int unsigned VEC_BASE = 'h100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boundary,
  input  logic          rti_req,
  input  logic          take,
  input  evt_src_t      sel_src,
  input  logic [VW-1:0] sel_vec,
  input  logic [DW-1:0] psr_entry,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] psr_in,
  input  logic [AW-1:0] sp_in,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          dev_ack,
  output logic          sync_ack,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] psr_out,
  output logic [AW-1:0] sp_out,
  output logic          pc_load,
  output logic          psr_load,
  output logic          sp_load,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  localparam logic [AW-1:0] TBL_BASE = AW'(VEC_BASE);
  localparam logic [AW-1:0] ONE      = AW'(1);

  seq_state_t    state;
  logic [AW-1:0] sp_w;
  logic [DW-1:0] pc_sv;
  logic [DW-1:0] sr_sv;
  logic [DW-1:0] sr_new;
  logic [VW-1:0] vec_r;
  logic [DW-1:0] pc_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      sp_w      <= '0;
      pc_sv     <= '0;
      sr_sv     <= '0;
      sr_new    <= '0;
      vec_r     <= '0;
      pc_hold   <= '0;
      done      <= 1'b0;
      dev_ack   <= 1'b0;
      sync_ack  <= 1'b0;
      pc_out    <= '0;
      psr_out   <= '0;
      sp_out    <= '0;
      pc_load   <= 1'b0;
      psr_load  <= 1'b0;
      sp_load   <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      done     <= 1'b0;
      dev_ack  <= 1'b0;
      sync_ack <= 1'b0;
      pc_load  <= 1'b0;
      psr_load <= 1'b0;
      sp_load  <= 1'b0;
      mem_req  <= 1'b0;
      mem_we   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (boundary) begin
            if (take) begin
              pc_sv    <= pc_in;
              sr_sv    <= psr_in;
              sr_new   <= psr_entry;
              vec_r    <= sel_vec;
              sp_w     <= sp_in;
              dev_ack  <= (sel_src == SRC_DEV);
              sync_ack <= (sel_src != SRC_DEV);
              state    <= S_PUSH_SR;
            end else begin
              done <= 1'b1;
            end
          end else if (rti_req) begin
            sp_w  <= sp_in;
            state <= S_RET_A;
          end
        end
        S_PUSH_SR: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= sp_w - ONE;
          mem_wdata <= sr_sv;
          sp_w      <= sp_w - ONE;
          state     <= S_PUSH_PC;
        end
        S_PUSH_PC: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= sp_w - ONE;
          mem_wdata <= pc_sv;
          sp_w      <= sp_w - ONE;
          state     <= S_VEC_RD;
        end
        S_VEC_RD: begin
          mem_req  <= 1'b1;
          mem_addr <= TBL_BASE + AW'(vec_r);
          state    <= S_VEC_WT;
        end
        S_VEC_WT: begin
          state <= S_VEC_LD;
        end
        S_VEC_LD: begin
          pc_out   <= mem_rdata;
          psr_out  <= sr_new;
          sp_out   <= sp_w;
          pc_load  <= 1'b1;
          psr_load <= 1'b1;
          sp_load  <= 1'b1;
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        S_RET_A: begin
          mem_req  <= 1'b1;
          mem_addr <= sp_w;
          sp_w     <= sp_w + ONE;
          state    <= S_RET_B;
        end
        S_RET_B: begin
          mem_req  <= 1'b1;
          mem_addr <= sp_w;
          sp_w     <= sp_w + ONE;
          state    <= S_RET_C;
        end
        S_RET_C: begin
          pc_hold <= mem_rdata;
          state   <= S_RET_D;
        end
        S_RET_D: begin
          pc_out   <= pc_hold;
          psr_out  <= mem_rdata;
          sp_out   <= sp_w;
          pc_load  <= 1'b1;
          psr_load <= 1'b1;
          sp_load  <= 1'b1;
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5: back-to-back writes walk the stack downward one word at a time.
  a_r5_push_descends: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && $past(mem_req && mem_we)) |->
      (mem_addr == $past(mem_addr) - ONE));

  // R8: back-to-back reads walk the stack upward one word at a time.
  a_r8_pop_ascends: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && $past(mem_req && !mem_we)) |->
      (mem_addr == $past(mem_addr) + ONE));

  // R10: completion is only signalled once the sequencer is back at rest.
  a_r10_done_at_rest: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == S_IDLE));

  // R11: no memory traffic while resting.
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == S_IDLE && state == S_IDLE) |-> !mem_req);

endmodule

// File: rtl/excp_entry_seq.sv
module excp_entry_seq
  import excp_seq_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 16,
  parameter int          VW       = 8,
  parameter int          PW       = 3,
  parameter int          PRIO_LSB = 8,
  parameter int          PRIV_POS = 15,
  parameter int unsigned VEC_BASE = 'h100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boundary,
  input  logic          rti_req,
  output logic          done,
  input  logic          exc_req,
  input  logic [VW-1:0] exc_vec,
  input  logic          trap_req,
  input  logic [VW-1:0] trap_vec,
  input  logic          irq_req,
  input  logic [VW-1:0] irq_vec,
  input  logic [PW-1:0] irq_prio,
  input  logic          irq_en,
  output logic          irq_ack,
  output logic          sync_ack,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] psr_in,
  input  logic [AW-1:0] sp_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] psr_out,
  output logic [AW-1:0] sp_out,
  output logic          pc_load,
  output logic          psr_load,
  output logic          sp_load,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  logic [PW-1:0] cur_prio;
  logic          take;
  evt_src_t      sel_src;
  logic [VW-1:0] sel_vec;
  logic [DW-1:0] psr_entry;
  logic          raise;

  assign cur_prio = psr_in[PRIO_LSB +: PW];
  assign raise    = (sel_src == SRC_DEV);

  evt_arbiter #(.VW(VW), .PW(PW)) u_arb (
    .fault_req (exc_req),
    .fault_vec (exc_vec),
    .trap_req  (trap_req),
    .trap_vec  (trap_vec),
    .dev_req   (irq_req),
    .dev_vec   (irq_vec),
    .dev_prio  (irq_prio),
    .dev_en    (irq_en),
    .cur_prio  (cur_prio),
    .take      (take),
    .sel_src   (sel_src),
    .sel_vec   (sel_vec)
  );

  psr_builder #(.DW(DW), .PRIV_POS(PRIV_POS), .PRIO_LSB(PRIO_LSB), .PW(PW)) u_psr (
    .psr_old (psr_in),
    .raise   (raise),
    .prio    (irq_prio),
    .psr_new (psr_entry)
  );

  seq_core #(.AW(AW), .DW(DW), .VW(VW), .VEC_BASE(VEC_BASE)) u_core (
    .clk       (clk),
    .rst       (rst),
    .boundary  (boundary),
    .rti_req   (rti_req),
    .take      (take),
    .sel_src   (sel_src),
    .sel_vec   (sel_vec),
    .psr_entry (psr_entry),
    .pc_in     (pc_in),
    .psr_in    (psr_in),
    .sp_in     (sp_in),
    .mem_rdata (mem_rdata),
    .done      (done),
    .dev_ack   (irq_ack),
    .sync_ack  (sync_ack),
    .pc_out    (pc_out),
    .psr_out   (psr_out),
    .sp_out    (sp_out),
    .pc_load   (pc_load),
    .psr_load  (psr_load),
    .sp_load   (sp_load),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  // R3: an accepted device request was enabled and outranked the running level.
  a_r3_dev_outranks: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> ($past(irq_en) && ($past(irq_prio) > $past(psr_in[PRIO_LSB +: PW]))));

  // R4: a device is never acknowledged over a pending synchronous request.
  a_r4_sync_first: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> !$past(exc_req || trap_req));

  // R9: the two acknowledges never coincide.
  a_r9_ack_excl: assert property (@(posedge clk) disable iff (rst)
    !(irq_ack && sync_ack));

  // R10: register loads only appear with completion.
  a_r10_load_done: assert property (@(posedge clk) disable iff (rst)
    (pc_load || psr_load || sp_load) |-> done);

endmodule

// File: tb/sim_excp_entry_seq.sv
`timescale 1ns/1ps
module sim_excp_entry_seq;

  localparam logic [15:0] VBASE = 16'h0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        boundary = 0, rti_req = 0, done;
  logic        exc_req = 0, trap_req = 0, irq_req = 0, irq_en = 0;
  logic [7:0]  exc_vec = 0, trap_vec = 0, irq_vec = 0;
  logic [2:0]  irq_prio = 0;
  logic        irq_ack, sync_ack;
  logic [15:0] pc_in = 0, psr_in = 0, sp_in = 0;
  logic [15:0] pc_out, psr_out, sp_out;
  logic        pc_load, psr_load, sp_load;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = 0;

  excp_entry_seq u0 (
    .clk(clk), .rst(rst), .boundary(boundary), .rti_req(rti_req), .done(done),
    .exc_req(exc_req), .exc_vec(exc_vec), .trap_req(trap_req), .trap_vec(trap_vec),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_prio(irq_prio), .irq_en(irq_en),
    .irq_ack(irq_ack), .sync_ack(sync_ack),
    .pc_in(pc_in), .psr_in(psr_in), .sp_in(sp_in),
    .pc_out(pc_out), .psr_out(psr_out), .sp_out(sp_out),
    .pc_load(pc_load), .psr_load(psr_load), .sp_load(sp_load),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Synchronous memory model: one-cycle read latency.
  logic [15:0] mem [0:1023];
  int          wr_n = 0, rd_n = 0;
  logic [15:0] rd_log [0:3];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[9:0]] <= mem_wdata;
        wr_n++;
      end else begin
        mem_rdata <= mem[mem_addr[9:0]];
        if (rd_n < 4) rd_log[rd_n] <= mem_addr;
        rd_n++;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] tbl(input logic [7:0] v);
    return {4'hC, v, 4'h5};
  endfunction

  // Outcome from the requirements: 0 none, 1 fault, 2 trap, 3 device.
  function automatic int pick(input logic e, input logic t, input logic i,
                              input logic en, input logic [2:0] p, input logic [15:0] psr);
    if (e) return 1;
    if (t) return 2;
    if (i && en && (p > psr[10:8])) return 3;
    return 0;
  endfunction

  // Run one boundary check; returns the new status word and stack pointer.
  task automatic evt(input logic e, input logic [7:0] ev, input logic t, input logic [7:0] tv,
                     input logic i, input logic [7:0] iv, input logic [2:0] ip, input logic en,
                     input logic [15:0] pc, input logic [15:0] psr, input logic [15:0] sp,
                     output logic [15:0] npsr, output logic [15:0] nsp);
    int src, lat, w0;
    logic [7:0]  xv;
    logic [15:0] xpsr;
    src  = pick(e, t, i, en, ip, psr);
    xv   = (src == 1) ? ev : (src == 2) ? tv : iv;
    xpsr = psr;
    xpsr[15] = 1'b0;
    if (src == 3) xpsr[10:8] = ip;
    @(negedge clk);
    exc_req = e; exc_vec = ev; trap_req = t; trap_vec = tv;
    irq_req = i; irq_vec = iv; irq_prio = ip; irq_en = en;
    pc_in = pc; psr_in = psr; sp_in = sp; boundary = 1;
    w0 = wr_n; rd_n = 0;
    @(negedge clk);
    boundary = 0;
    // R9: acknowledge right after the sampling edge
    chk(irq_ack == (src == 3), "R9 irq_ack", irq_ack, src == 3);
    chk(sync_ack == (src == 1 || src == 2), "R9 sync_ack", sync_ack, src == 1 || src == 2);
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
      // R11: strobes during a sequence are ignored
      if (lat == 1) boundary = 1;
      if (lat == 2) begin boundary = 0; rti_req = 1; end
      if (lat == 3) rti_req = 0;
    end
    boundary = 0; rti_req = 0;
    exc_req = 0; trap_req = 0; irq_req = 0;
    npsr = psr; nsp = sp;
    if (src == 0) begin
      chk(lat == 0, "R2 done latency", lat, 0);
      chk(!pc_load && !psr_load && !sp_load, "R2 no load", {pc_load, psr_load, sp_load}, 0);
      chk(wr_n == w0 && rd_n == 0, "R3 ignored no memory", wr_n - w0 + rd_n, 0);
    end else begin
      chk(lat == 5, "R10 entry latency", lat, 5);
      chk(pc_load && psr_load && sp_load, "R10 loads", {pc_load, psr_load, sp_load}, 3'b111);
      chk(wr_n - w0 == 2, "R5 write count", wr_n - w0, 2);
      chk(mem[10'(sp - 16'd1)] == psr, "R5 status pushed", mem[10'(sp - 16'd1)], psr);
      chk(mem[10'(sp - 16'd2)] == pc, "R5 pc pushed", mem[10'(sp - 16'd2)], pc);
      chk(rd_n == 1 && rd_log[0] == VBASE + {8'h0, xv}, "R6 table addr", rd_log[0], VBASE + {8'h0, xv});
      chk(pc_out == tbl(xv), "R4 R6 handler pc", pc_out, tbl(xv));
      chk(sp_out == sp - 16'd2, "R6 sp", sp_out, sp - 16'd2);
      chk(psr_out == xpsr, "R7 entry status", psr_out, xpsr);
      npsr = psr_out; nsp = sp_out;
    end
    @(negedge clk);
    chk(!done, "R10 done single pulse", done, 0);
  endtask

  task automatic ret(input logic [15:0] sp, input logic [15:0] xpc, input logic [15:0] xpsr);
    int lat;
    @(negedge clk);
    sp_in = sp; rti_req = 1; rd_n = 0;
    @(negedge clk);
    rti_req = 0;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 4, "R10 return latency", lat, 4);
    chk(rd_n == 2 && rd_log[0] == sp && rd_log[1] == sp + 16'd1, "R8 pop order",
        {rd_log[0], rd_log[1]}, {sp, sp + 16'd1});
    chk(pc_out == xpc, "R8 restored pc", pc_out, xpc);
    chk(psr_out == xpsr, "R8 restored status", psr_out, xpsr);
    chk(sp_out == sp + 16'd2, "R8 restored sp", sp_out, sp + 16'd2);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] p1, s1, p2, s2, p3, s3;
    void'($urandom(32'd1234));
    for (int k = 0; k < 1024; k++) mem[k] = 16'h0;
    for (int k = 0; k < 256; k++) mem[k + 256] = tbl(8'(k));
    repeat (3) @(negedge clk);
    chk(!done && !irq_ack && !sync_ack && !pc_load && !psr_load && !sp_load && !mem_req && !mem_we,
        "R1 reset outputs", {done, irq_ack, sync_ack, pc_load, mem_req}, 0);
    rst = 0;
    @(negedge clk);
    chk(!done && !mem_req && !pc_load, "R1 after reset", {done, mem_req, pc_load}, 0);

    // R2 R3: disabled, equal and lower priority are ignored
    evt(0, 0, 0, 0, 1, 8'h80, 3'd6, 0, 16'h3005, 16'h8302, 16'h0300, p1, s1);
    evt(0, 0, 0, 0, 1, 8'h80, 3'd3, 1, 16'h3005, 16'h8302, 16'h0300, p1, s1);
    evt(0, 0, 0, 0, 1, 8'h80, 3'd2, 1, 16'h3005, 16'h8302, 16'h0300, p1, s1);
    // R4: all three pending -> fault; trap + device -> trap
    evt(1, 8'h01, 1, 8'h25, 1, 8'h80, 3'd7, 1, 16'h3006, 16'h8302, 16'h0300, p1, s1);
    ret(s1, 16'h3006, 16'h8302);
    evt(0, 8'h01, 1, 8'h25, 1, 8'h80, 3'd7, 1, 16'h3007, 16'h8104, 16'h0300, p1, s1);
    ret(s1, 16'h3007, 16'h8104);

    // R11 nesting: enter at 3, refuse equal 3, accept 5, unwind twice
    evt(0, 0, 0, 0, 1, 8'h80, 3'd3, 1, 16'h3005, 16'h8001, 16'h0300, p1, s1);
    evt(0, 0, 0, 0, 1, 8'h81, 3'd3, 1, 16'h4000, p1, s1, p2, s2);
    chk(s2 == s1, "R11 equal level refused", s2, s1);
    evt(0, 0, 0, 0, 1, 8'h82, 3'd5, 1, 16'h4010, p1, s1, p3, s3);
    chk(p3[10:8] == 3'd5, "R7 nested priority", p3[10:8], 3'd5);
    ret(s3, 16'h4010, p1);
    ret(s1, 16'h3005, 16'h8001);

    // Random mix, each taken entry followed by a return
    for (int it = 0; it < 40; it++) begin
      logic e, t, i, en;
      logic [7:0] ev, tv, iv;
      logic [2:0] ip;
      logic [15:0] pc, psr, sp;
      e  = ($urandom % 6) == 0;
      t  = ($urandom % 5) == 0;
      i  = ($urandom % 2) == 0;
      en = ($urandom % 4) != 0;
      ev = 8'($urandom); tv = 8'($urandom); iv = 8'($urandom);
      ip = 3'($urandom);
      pc = 16'($urandom); psr = 16'($urandom);
      sp = 16'h0280 + 16'($urandom % 128);
      evt(e, ev, t, tv, i, iv, ip, en, pc, psr, sp, p1, s1);
      if (pick(e, t, i, en, ip, psr) != 0) ret(s1, pc, psr);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule